// File: doc/BRIEF.md
# Extended Register-Pair Execution Unit

This unit carries out a handful of extra opcodes of an 8-bit processor that act on 16-bit register pairs. The core's decoder hands it the opcode, an immediate byte, a jump target and the current BC, DE, HL, SP, PC and flag values, and pulses `start`. The unit captures everything it needs on that edge. It then returns the updated HL, DE, SP, PC, flags and a jump decision, and marks them valid with a one-cycle `done` pulse.

Pair subtract, pair rotates, immediate adds and conditional jumps finish one cycle after `start`. The indirect HL load and store go through a byte-wide synchronous memory port. So does the overflow restart, which writes the return address to the stack. During these operations `busy` stays high, and the unit ignores `start`.

The flag byte uses this layout: bit 7 sign (S), bit 6 zero (Z), bit 5 the extra K flag, bit 4 half borrow (AC), bit 3 kept as given, bit 2 parity (P, set for an even number of ones), bit 1 signed overflow (V), bit 0 carry (CY). The memory port has a read latency of one cycle: `mem_rdata` holds the byte addressed by a `mem_rd` cycle in the following cycle.

Top module: `xpair_exec_unit`

## Requirements
- R1: Opcode 08h writes HL-BC (mod 2^16) to HL. It sets CY on unsigned borrow, S to result bit 15, Z when the result is zero, P when the result's low byte has even parity, AC when HL[3:0] < BC[3:0], and both V and K when the signed result leaves -32768..32767. Bit 3 keeps its value.
- R2: Opcode 10h rotates HL right through carry: new HL = {CY, HL[15:1]}, new CY = old HL[0]. No other flag changes.
- R3: Opcode 18h rotates DE left through carry: new DE = {DE[14:0], CY}, new CY = old DE[15]. No other flag changes.
- R4: Opcode 28h adds the zero-extended immediate to HL. CY takes the carry out of bit 15, and V and K are both set when the signed sum exceeds 32767. The other flags do not change.
- R5: Opcode 38h adds the zero-extended immediate to SP modulo 2^16 and leaves every flag unchanged.
- R6: Opcode EDh reads the byte at DE (cycle 1) and at DE+1 (cycle 2), and loads them into L and H. `done` rises 4 cycles after the start edge.
- R7: Opcode D9h writes L to DE (cycle 1) and H to DE+1 (cycle 2). `done` rises 3 cycles after the start edge.
- R8: Opcode CBh with V=1 writes PC[15:8] to SP-1 and then PC[7:0] to SP-2. It returns SP-2, PC=0040h and jump=1, with `done` after 3 cycles. With V=0 it finishes in one cycle with no change.
- R9: Opcode FDh jumps (PC=target, jump=1) when flag bit 5 is set. Opcode DDh jumps when bit 5 is clear. Otherwise PC is returned unchanged with jump=0.
- R10: Any other opcode returns all inputs unchanged with jump=0, makes no memory access and finishes one cycle after `start`. `done` is never high while `busy` is.
- R11: A `start` pulse while `busy` is high is ignored. The operation in progress completes with its original results and timing.
- R12: While reset is asserted, every output is zero.
- R13: `mem_rd` and `mem_wr` are never high together, and are high only while `busy` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue pulse; inputs sampled on this edge |
| opcode | input | 8 | Decoded opcode |
| imm | input | 8 | Immediate byte |
| bc_in | input | 16 | BC pair |
| de_in | input | 16 | DE pair |
| hl_in | input | 16 | HL pair |
| sp_in | input | 16 | Stack pointer |
| pc_in | input | 16 | Address of next instruction |
| target_in | input | 16 | Conditional jump destination |
| flags_in | input | 8 | Flag byte |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| hl_out | output | 16 | Result HL |
| de_out | output | 16 | Result DE |
| sp_out | output | 16 | Result SP |
| pc_out | output | 16 | Result PC |
| flags_out | output | 8 | Result flags |
| jump_taken | output | 1 | Control transfer taken |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |

## Verification
The assertions assume a memory that answers a read one cycle after the strobe and never stalls. They also assume that `done` is the only point at which results are consumed. The bench's memory model follows that latency exactly. It issues each operation only after the previous `done`, except for one deliberate `start` raised mid-transfer to exercise R11. Register and memory values for the indirect transfers stay within a 256-byte window that the bench memory models, so addresses wrap there consistently.

// File: rtl/xpx_pkg.sv
package xpx_pkg;
  localparam logic [7:0] OP_PAIR_SUB  = 8'h08;
  localparam logic [7:0] OP_HL_ROR    = 8'h10;
  localparam logic [7:0] OP_DE_ROL    = 8'h18;
  localparam logic [7:0] OP_HL_ADDI   = 8'h28;
  localparam logic [7:0] OP_SP_ADDI   = 8'h38;
  localparam logic [7:0] OP_OVF_TRAP  = 8'hCB;
  localparam logic [7:0] OP_HL_LOAD   = 8'hED;
  localparam logic [7:0] OP_HL_STORE  = 8'hD9;
  localparam logic [7:0] OP_JMP_KCLR  = 8'hDD;
  localparam logic [7:0] OP_JMP_KSET  = 8'hFD;

  localparam int FB_CY = 0;
  localparam int FB_V  = 1;
  localparam int FB_P  = 2;
  localparam int FB_AC = 4;
  localparam int FB_K  = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  typedef enum logic [1:0] {
    XF_NONE,
    XF_LOAD,
    XF_STORE,
    XF_PUSH
  } xfer_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_LO,
    SQ_RD_HI,
    SQ_RD_END,
    SQ_WR_LO,
    SQ_WR_HI,
    SQ_PU_HI,
    SQ_PU_LO
  } seq_state_t;
endpackage

// File: rtl/xpx_alu.sv
module xpx_alu
  import xpx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [7:0]          op,
  input  logic [DATA_W-1:0]   imm,
  input  logic [2*DATA_W-1:0] bc,
  input  logic [2*DATA_W-1:0] de,
  input  logic [2*DATA_W-1:0] hl,
  input  logic [2*DATA_W-1:0] sp,
  input  logic [DATA_W-1:0]   fl,
  output logic [2*DATA_W-1:0] hl_n,
  output logic [2*DATA_W-1:0] de_n,
  output logic [2*DATA_W-1:0] sp_n,
  output logic [DATA_W-1:0]   fl_n
);
  localparam int PW = 2 * DATA_W;
  localparam int XW = PW - DATA_W;

  logic [PW:0]   diff;
  logic [PW:0]   sum;
  logic [PW-1:0] imm_x;
  logic          sub_ovf;
  logic          add_ovf;

  always_comb begin
    imm_x   = {{XW{1'b0}}, imm};
    diff    = {1'b0, hl} - {1'b0, bc};
    sum     = {1'b0, hl} + {1'b0, imm_x};
    sub_ovf = (hl[PW-1] != bc[PW-1]) && (diff[PW-1] != hl[PW-1]);
    add_ovf = !hl[PW-1] && sum[PW-1];
  end

  always_comb begin
    hl_n = hl;
    de_n = de;
    sp_n = sp;
    fl_n = fl;
    case (op)
      OP_PAIR_SUB: begin
        hl_n        = diff[PW-1:0];
        fl_n[FB_CY] = diff[PW];
        fl_n[FB_S]  = diff[PW-1];
        fl_n[FB_Z]  = (diff[PW-1:0] == '0);
        fl_n[FB_P]  = ~^diff[DATA_W-1:0];
        fl_n[FB_AC] = (hl[3:0] < bc[3:0]);
        fl_n[FB_V]  = sub_ovf;
        fl_n[FB_K]  = sub_ovf;
      end
      OP_HL_ROR: begin
        hl_n        = {fl[FB_CY], hl[PW-1:1]};
        fl_n[FB_CY] = hl[0];
      end
      OP_DE_ROL: begin
        de_n        = {de[PW-2:0], fl[FB_CY]};
        fl_n[FB_CY] = de[PW-1];
      end
      OP_HL_ADDI: begin
        hl_n        = sum[PW-1:0];
        fl_n[FB_CY] = sum[PW];
        fl_n[FB_V]  = add_ovf;
        fl_n[FB_K]  = add_ovf;
      end
      OP_SP_ADDI: begin
        sp_n = sp + imm_x;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/xpx_branch.sv
module xpx_branch
  import xpx_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [2*DATA_W-1:0] RST_VEC = 16'h0040
) (
  input  logic [7:0]          op,
  input  logic                k_flag,
  input  logic                v_flag,
  input  logic [2*DATA_W-1:0] pc,
  input  logic [2*DATA_W-1:0] sp,
  input  logic [2*DATA_W-1:0] tgt,
  output logic                take,
  output logic                push,
  output logic [2*DATA_W-1:0] pc_n,
  output logic [2*DATA_W-1:0] sp_n
);
  localparam int PW = 2 * DATA_W;

  always_comb begin
    take = 1'b0;
    push = 1'b0;
    case (op)
      OP_JMP_KCLR: take = !k_flag;
      OP_JMP_KSET: take = k_flag;
      OP_OVF_TRAP: begin
        take = v_flag;
        push = v_flag;
      end
      default: begin
      end
    endcase
  end

  always_comb begin
    pc_n = pc;
    sp_n = sp;
    if (push) begin
      pc_n = RST_VEC;
      sp_n = sp - PW'(2);
    end else if (take) begin
      pc_n = tgt;
    end
  end
endmodule

// File: rtl/xpx_seq.sv
module xpx_seq
  import xpx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  xfer_kind_t          kind,
  input  logic [2*DATA_W-1:0] de,
  input  logic [2*DATA_W-1:0] hl,
  input  logic [2*DATA_W-1:0] sp,
  input  logic [2*DATA_W-1:0] pc,
  output logic                busy,
  output logic                finish,
  output logic                cap_lo,
  output logic                cap_hi,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);
  localparam int PW = 2 * DATA_W;

  seq_state_t    state_q, state_d;
  logic [PW-1:0] base_q, base_d;
  logic [PW-1:0] dat_q, dat_d;
  logic          ld_en;

  assign ld_en = launch && (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    dat_d   = dat_q;
    case (state_q)
      SQ_IDLE: begin
        if (launch) begin
          case (kind)
            XF_LOAD: begin
              state_d = SQ_RD_LO;
              base_d  = de;
            end
            XF_STORE: begin
              state_d = SQ_WR_LO;
              base_d  = de;
              dat_d   = hl;
            end
            XF_PUSH: begin
              state_d = SQ_PU_HI;
              base_d  = sp - PW'(1);
              dat_d   = pc;
            end
            default: state_d = SQ_IDLE;
          endcase
        end
      end
      SQ_RD_LO:  state_d = SQ_RD_HI;
      SQ_RD_HI:  state_d = SQ_RD_END;
      SQ_RD_END: state_d = SQ_IDLE;
      SQ_WR_LO:  state_d = SQ_WR_HI;
      SQ_WR_HI:  state_d = SQ_IDLE;
      SQ_PU_HI:  state_d = SQ_PU_LO;
      SQ_PU_LO:  state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dat_q  <= '0;
    end else if (ld_en) begin
      base_q <= base_d;
      dat_q  <= dat_d;
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      SQ_RD_LO: begin
        mem_rd   = 1'b1;
        mem_addr = base_q;
      end
      SQ_RD_HI: begin
        mem_rd   = 1'b1;
        mem_addr = base_q + PW'(1);
      end
      SQ_WR_LO: begin
        mem_wr    = 1'b1;
        mem_addr  = base_q;
        mem_wdata = dat_q[DATA_W-1:0];
      end
      SQ_WR_HI: begin
        mem_wr    = 1'b1;
        mem_addr  = base_q + PW'(1);
        mem_wdata = dat_q[PW-1:DATA_W];
      end
      SQ_PU_HI: begin
        mem_wr    = 1'b1;
        mem_addr  = base_q;
        mem_wdata = dat_q[PW-1:DATA_W];
      end
      SQ_PU_LO: begin
        mem_wr    = 1'b1;
        mem_addr  = base_q - PW'(1);
        mem_wdata = dat_q[DATA_W-1:0];
      end
      default: begin
      end
    endcase
  end

  assign busy   = (state_q != SQ_IDLE);
  assign cap_lo = (state_q == SQ_RD_HI);
  assign cap_hi = (state_q == SQ_RD_END);
  assign finish = (state_q == SQ_RD_END) || (state_q == SQ_WR_HI) || (state_q == SQ_PU_LO);
endmodule

// File: rtl/xpair_exec_unit.sv
module xpair_exec_unit
  import xpx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] RST_VEC = 16'h0040
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          opcode,
  input  logic [DATA_W-1:0]   imm,
  input  logic [2*DATA_W-1:0] bc_in,
  input  logic [2*DATA_W-1:0] de_in,
  input  logic [2*DATA_W-1:0] hl_in,
  input  logic [2*DATA_W-1:0] sp_in,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [2*DATA_W-1:0] target_in,
  input  logic [DATA_W-1:0]   flags_in,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] hl_out,
  output logic [2*DATA_W-1:0] de_out,
  output logic [2*DATA_W-1:0] sp_out,
  output logic [2*DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0]   flags_out,
  output logic                jump_taken,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int PW = 2 * DATA_W;

  logic [PW-1:0]     alu_hl, alu_de, alu_sp, br_pc, br_sp;
  logic [DATA_W-1:0] alu_fl;
  logic              br_take, br_push;
  logic              accept, single, seq_finish, cap_lo, cap_hi;
  xfer_kind_t        kind;

  logic [PW-1:0]     hl_q, hl_d, de_q, de_d, sp_q, sp_d, pc_q, pc_d;
  logic [DATA_W-1:0] fl_q, fl_d;
  logic              jmp_q, jmp_d, done_q, done_d;
  logic              res_en;

  xpx_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (opcode),
    .imm  (imm),
    .bc   (bc_in),
    .de   (de_in),
    .hl   (hl_in),
    .sp   (sp_in),
    .fl   (flags_in),
    .hl_n (alu_hl),
    .de_n (alu_de),
    .sp_n (alu_sp),
    .fl_n (alu_fl)
  );

  xpx_branch #(.DATA_W(DATA_W), .RST_VEC(RST_VEC)) u_br (
    .op     (opcode),
    .k_flag (flags_in[FB_K]),
    .v_flag (flags_in[FB_V]),
    .pc     (pc_in),
    .sp     (alu_sp),
    .tgt    (target_in),
    .take   (br_take),
    .push   (br_push),
    .pc_n   (br_pc),
    .sp_n   (br_sp)
  );

  always_comb begin
    if (opcode == OP_HL_LOAD)       kind = XF_LOAD;
    else if (opcode == OP_HL_STORE) kind = XF_STORE;
    else if (br_push)               kind = XF_PUSH;
    else                            kind = XF_NONE;
  end

  assign accept = start && !busy;
  assign single = accept && (kind == XF_NONE);

  xpx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (accept),
    .kind      (kind),
    .de        (de_in),
    .hl        (hl_in),
    .sp        (sp_in),
    .pc        (pc_in),
    .busy      (busy),
    .finish    (seq_finish),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign res_en = accept || cap_lo || cap_hi;

  always_comb begin
    hl_d   = hl_q;
    de_d   = de_q;
    sp_d   = sp_q;
    pc_d   = pc_q;
    fl_d   = fl_q;
    jmp_d  = jmp_q;
    done_d = single || seq_finish;
    if (accept) begin
      hl_d  = alu_hl;
      de_d  = alu_de;
      sp_d  = br_sp;
      pc_d  = br_pc;
      fl_d  = alu_fl;
      jmp_d = br_take;
    end else if (cap_lo) begin
      hl_d[DATA_W-1:0] = mem_rdata;
    end else if (cap_hi) begin
      hl_d[PW-1:DATA_W] = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q  <= '0;
      de_q  <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
      fl_q  <= '0;
      jmp_q <= 1'b0;
    end else if (res_en) begin
      hl_q  <= hl_d;
      de_q  <= de_d;
      sp_q  <= sp_d;
      pc_q  <= pc_d;
      fl_q  <= fl_d;
      jmp_q <= jmp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign hl_out     = hl_q;
  assign de_out     = de_q;
  assign sp_out     = sp_q;
  assign pc_out     = pc_q;
  assign flags_out  = fl_q;
  assign jump_taken = jmp_q;
  assign done       = done_q;
endmodule

// File: rtl/xpx_exec_chk.sv
module xpx_exec_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic [2*DATA_W-1:0] mem_addr
);
  localparam int PW = 2 * DATA_W;

  // R13: strobes only inside an operation
  p_strobe_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  // R13: never read and write together
  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10: results are never flagged while still busy
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: second read byte sits one above the first
  p_read_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == PW'($past(mem_addr) + 1'b1)));

  // R7 / R8: paired writes target adjacent bytes
  p_write_adj_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |->
      ((mem_addr == PW'($past(mem_addr) + 1'b1)) || (mem_addr == PW'($past(mem_addr) - 1'b1))));

  // R8: end of a multi-cycle operation always reports completion
  p_busy_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind xpair_exec_unit xpx_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr)
);

// File: tb/xpair_exec_unit_test.sv
module xpair_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, imm, flags_in, flags_out, mem_wdata, mem_rdata;
  logic [15:0] bc_in, de_in, hl_in, sp_in, pc_in, target_in;
  logic [15:0] hl_out, de_out, sp_out, pc_out, mem_addr;
  logic        busy, done, jump_taken, mem_rd, mem_wr;
  logic [7:0]  mem [0:255];
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  xpair_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
    .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .sp_in(sp_in), .pc_in(pc_in),
    .target_in(target_in), .flags_in(flags_in), .busy(busy), .done(done),
    .hl_out(hl_out), .de_out(de_out), .sp_out(sp_out), .pc_out(pc_out),
    .flags_out(flags_out), .jump_taken(jump_taken), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int sgn16(input logic [15:0] v);
    return (int'(v) >= 32768) ? int'(v) - 65536 : int'(v);
  endfunction

  task automatic issue(input string req, input logic [7:0] op, input logic [7:0] im,
                       input logic [15:0] bc, input logic [15:0] de, input logic [15:0] hl,
                       input logic [15:0] sp, input logic [15:0] pc, input logic [15:0] tg,
                       input logic [7:0] fl, input bit poke);
    logic [15:0] e_hl, e_de, e_sp, e_pc;
    logic [7:0]  e_fl;
    logic        e_j;
    int          lat, r, sd;
    logic        x_rd [1:4];
    logic        x_wr [1:4];
    logic [15:0] x_ad [1:4];
    logic [7:0]  x_wd [1:4];
    e_hl = hl; e_de = de; e_sp = sp; e_pc = pc; e_fl = fl; e_j = 1'b0; lat = 1;
    for (int i = 1; i <= 4; i++) begin
      x_rd[i] = 0; x_wr[i] = 0; x_ad[i] = '0; x_wd[i] = '0;
    end
    case (op)
      8'h08: begin
        r = int'(hl) - int'(bc);
        e_hl = 16'(r);
        e_fl[0] = (r < 0);
        e_fl[7] = e_hl[15];
        e_fl[6] = (e_hl == 0);
        e_fl[2] = ($countones(e_hl[7:0]) % 2 == 0);
        e_fl[4] = (int'(hl[3:0]) < int'(bc[3:0]));
        sd = sgn16(hl) - sgn16(bc);
        e_fl[1] = (sd > 32767) || (sd < -32768);
        e_fl[5] = e_fl[1];
      end
      8'h10: begin e_hl = (hl >> 1) | (16'(fl[0]) << 15); e_fl[0] = hl[0]; end
      8'h18: begin e_de = (de << 1) | 16'(fl[0]); e_fl[0] = de[15]; end
      8'h28: begin
        r = int'(hl) + int'(im);
        e_hl = 16'(r);
        e_fl[0] = (r > 65535);
        e_fl[1] = (sgn16(hl) + int'(im)) > 32767;
        e_fl[5] = e_fl[1];
      end
      8'h38: e_sp = 16'(int'(sp) + int'(im));
      8'hCB: if (fl[1]) begin
        lat = 3; e_sp = sp - 16'd2; e_pc = 16'h0040; e_j = 1'b1;
        x_wr[1] = 1; x_ad[1] = sp - 16'd1; x_wd[1] = pc[15:8];
        x_wr[2] = 1; x_ad[2] = sp - 16'd2; x_wd[2] = pc[7:0];
      end
      8'hED: begin
        lat = 4;
        e_hl = {mem[8'(de + 16'd1)], mem[de[7:0]]};
        x_rd[1] = 1; x_ad[1] = de;
        x_rd[2] = 1; x_ad[2] = de + 16'd1;
      end
      8'hD9: begin
        lat = 3;
        x_wr[1] = 1; x_ad[1] = de; x_wd[1] = hl[7:0];
        x_wr[2] = 1; x_ad[2] = de + 16'd1; x_wd[2] = hl[15:8];
      end
      8'hDD: if (!fl[5]) begin e_pc = tg; e_j = 1'b1; end
      8'hFD: if (fl[5]) begin e_pc = tg; e_j = 1'b1; end
      default: begin end
    endcase
    @(negedge clk);
    opcode = op; imm = im; bc_in = bc; de_in = de; hl_in = hl; sp_in = sp;
    pc_in = pc; target_in = tg; flags_in = fl; start = 1'b1;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 1) begin
        // R11: competing start while busy, with other inputs
        start = 1'b1; opcode = 8'h08; hl_in = 16'h1357; de_in = 16'h0099; bc_in = 16'h0001;
      end
      chk(req, $sformatf("busy@%0d", k), 32'(busy), 32'(k < lat));
      chk(req, $sformatf("done@%0d", k), 32'(done), 32'(k == lat));
      chk("R13", $sformatf("rd@%0d", k), 32'(mem_rd), 32'(x_rd[k]));
      chk("R13", $sformatf("wr@%0d", k), 32'(mem_wr), 32'(x_wr[k]));
      if (x_rd[k] || x_wr[k]) chk(req, $sformatf("addr@%0d", k), 32'(mem_addr), 32'(x_ad[k]));
      if (x_wr[k]) chk(req, $sformatf("wdata@%0d", k), 32'(mem_wdata), 32'(x_wd[k]));
    end
    start = 1'b0;
    chk(req, "hl", 32'(hl_out), 32'(e_hl));
    chk(req, "de", 32'(de_out), 32'(e_de));
    chk(req, "sp", 32'(sp_out), 32'(e_sp));
    chk(req, "pc", 32'(pc_out), 32'(e_pc));
    chk(req, "flags", 32'(flags_out), 32'(e_fl));
    chk(req, "jump", 32'(jump_taken), 32'(e_j));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    mem[8'h10] = 8'hA5; mem[8'h11] = 8'h3C;
    rst_n = 1'b0; start = 1'b0; opcode = '0; imm = '0; bc_in = '0; de_in = '0;
    hl_in = '0; sp_in = '0; pc_in = '0; target_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "done", 32'(done), 0);
    chk("R12", "strobes", 32'({mem_rd, mem_wr}), 0);
    chk("R12", "results", 32'(hl_out | de_out | sp_out | pc_out), 0);
    chk("R12", "flags/jump", 32'({flags_out, jump_taken}), 0);
    rst_n = 1'b1;

    // R1: pair subtract, plain, overflow, borrow, zero with bit 3 kept
    issue("R1", 8'h08, 8'h00, 16'h03E8, 16'h1111, 16'h1388, 16'h2000, 16'h0100, 16'h0000, 8'h00, 0);
    issue("R1", 8'h08, 8'h00, 16'h0001, 16'h1111, 16'h8000, 16'h2000, 16'h0100, 16'h0000, 8'h00, 0);
    issue("R1", 8'h08, 8'h00, 16'h0002, 16'h1111, 16'h0001, 16'h2000, 16'h0100, 16'h0000, 8'h08, 0);
    issue("R1", 8'h08, 8'h00, 16'hABCD, 16'h1111, 16'hABCD, 16'h2000, 16'h0100, 16'h0000, 8'hFF, 0);
    // R2: HL right rotate through carry
    issue("R2", 8'h10, 8'h00, 16'h0000, 16'h0000, 16'h0003, 16'h2000, 16'h0100, 16'h0000, 8'h01, 0);
    issue("R2", 8'h10, 8'h00, 16'h0000, 16'h0000, 16'h8000, 16'h2000, 16'h0100, 16'h0000, 8'hF0, 0);
    // R3: DE left rotate through carry
    issue("R3", 8'h18, 8'h00, 16'h0000, 16'h8001, 16'h0000, 16'h2000, 16'h0100, 16'h0000, 8'h00, 0);
    issue("R3", 8'h18, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 16'h0100, 16'h0000, 8'h01, 0);
    // R4: immediate add to HL, signed overflow then unsigned carry
    issue("R4", 8'h28, 8'h20, 16'h0000, 16'h0000, 16'h7FF0, 16'h2000, 16'h0100, 16'h0000, 8'h00, 0);
    issue("R4", 8'h28, 8'h20, 16'h0000, 16'h0000, 16'hFFF0, 16'h2000, 16'h0100, 16'h0000, 8'hC4, 0);
    // R5: immediate add to SP wraps, flags untouched
    issue("R5", 8'h38, 8'h01, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0100, 16'h0000, 8'hA7, 0);
    // R6 + R11: indirect load with a competing start mid-transfer
    issue("R6", 8'hED, 8'h00, 16'h0000, 16'h0010, 16'h0000, 16'h2000, 16'h0100, 16'h0000, 8'h00, 1);
    // R7: indirect store, then memory contents and read-back
    issue("R7", 8'hD9, 8'h00, 16'h0000, 16'h0020, 16'hBEEF, 16'h2000, 16'h0100, 16'h0000, 8'h00, 1);
    chk("R7", "mem lo", 32'(mem[8'h20]), 32'h00EF);
    chk("R7", "mem hi", 32'(mem[8'h21]), 32'h00BE);
    issue("R6", 8'hED, 8'h00, 16'h0000, 16'h0020, 16'h0000, 16'h2000, 16'h0100, 16'h0000, 8'h00, 0);
    // R8: overflow restart taken and not taken
    issue("R8", 8'hCB, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0080, 16'h1234, 16'h0000, 8'h02, 0);
    chk("R8", "stack hi", 32'(mem[8'h7F]), 32'h0012);
    chk("R8", "stack lo", 32'(mem[8'h7E]), 32'h0034);
    issue("R8", 8'hCB, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0080, 16'h1234, 16'h0000, 8'hFD, 0);
    // R9: conditional jumps on bit 5
    issue("R9", 8'hFD, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 16'h0300, 16'h4567, 8'h20, 0);
    issue("R9", 8'hFD, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 16'h0300, 16'h4567, 8'hDF, 0);
    issue("R9", 8'hDD, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 16'h0300, 16'h89AB, 8'h00, 0);
    issue("R9", 8'hDD, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h2000, 16'h0300, 16'h89AB, 8'h20, 0);
    // R10: unrelated opcodes pass everything through
    issue("R10", 8'h00, 8'h55, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 8'hFF, 0);
    issue("R10", 8'h76, 8'h55, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 16'hEEEE, 16'h6666, 8'h22, 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule